// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Controller

This block generates two independent pulse-width-modulated outputs behind a small word-addressed register port. Each channel first slows the system clock with a divider chosen by a 4-bit code. The code table is sparse: several divide values between 120 and 72000, some reserved codes, and, as a build option, a divide-by-one bypass code. The divided ticks then drive a period counter, and the output sits at its active level for a programmed number of ticks at the start of every period.

Software sets the divider code, an enable bit, a clock-gate bit and an active-level bit for each channel in one shared control word. The period and duty of a channel go in that channel's own word: the upper half holds the period length minus one and the lower half holds the active tick count. A new period/duty word is held pending and takes effect only at the next period boundary, so a running waveform never shows a torn period. A per-channel ready flag in the control word shows whether a pending update is still waiting. The divider code can be changed only while the channel's gate bit is clear, and the divider restarts from zero when the gate opens again.

Top module: `twin_pwm_unit`

## Requirements
- R1: Word address 0 is the control word and word address 1+n is channel n's period/duty word, which reads back the last value written. Channel n's control field starts at bit 15*n and holds the divider code in bits [3:0], enable in bit 4, active level in bit 5 and gate in bit 6. Bits 7 and 8 of a field are not stored and read as 0. After reset every register reads 0.
- R2: Divider codes 0,1,2,3,4 divide by 120,180,240,360,480, and codes 8,9,10,11,12 divide by 12000,24000,36000,48000,72000.
- R3: When the bypass option is built in (the default), code 15 divides by one, so the channel advances one tick every clock.
- R4: Codes 5, 6, 7, 13 and 14 (and 15 without the bypass option) are reserved: a running channel with such a code holds its output at the inactive level.
- R5: A period/duty word with P in bits [31:16] and T in bits [15:0] gives a period of (P+1)*D clocks, with the output active for the first T*D clocks, where D is the divider.
- R6: A duty count of T >= P+1 keeps the output always active, and T = 0 keeps it always inactive.
- R7: A channel runs only while both its enable and gate bits are 1. Otherwise its output rests at the inactive level and its counters are held at zero.
- R8: With the active-level bit at 1 the output is high during the active portion. With it at 0 the output is inverted, so it idles high, and it idles high out of reset.
- R9: Control bit 28+n reads 1 from the clock after a write to channel n's word until that word is loaded. A running channel loads it at the end of the current period. A stopped channel loads it on the next clock.
- R10: A control write changes a channel's divider code only if that channel's stored gate bit is 0. Otherwise the old code is kept.
- R11: When a channel starts, its divider and period counter start from zero, so the first active interval lasts exactly T*D clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| pwm_out | output | NCH | Channel outputs, bit n for channel n |

## Verification
A wrong divider count shows at the port as a stretched or shrunk interval. It appears within the first active interval after a channel starts, which is T*D clocks long. A stuck pending flag shows as bit 28+n never clearing, and as the old period length persisting past the next boundary. A wrong run/gate decode or a bad polarity shows as a resting or inverted output level within one clock. A divider code that changes while the gate is set shows at once on control readback, and within one period in the measured timing.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int DIV_W  = 17;
  localparam int CODE_W = 4;

  // Divider value for a code; 0 marks a reserved code.
  function automatic logic [DIV_W-1:0] presc_div(input logic [CODE_W-1:0] code,
                                                  input bit bypass);
    logic [DIV_W-1:0] d;
    case (code)
      4'd0:    d = 17'd120;
      4'd1:    d = 17'd180;
      4'd2:    d = 17'd240;
      4'd3:    d = 17'd360;
      4'd4:    d = 17'd480;
      4'd8:    d = 17'd12000;
      4'd9:    d = 17'd24000;
      4'd10:   d = 17'd36000;
      4'd11:   d = 17'd48000;
      4'd12:   d = 17'd72000;
      4'd15:   d = bypass ? 17'd1 : 17'd0;
      default: d = 17'd0;
    endcase
    return d;
  endfunction

  // Active while the period count is below the duty count.
  function automatic logic duty_on(input logic [15:0] cnt, input logic [15:0] dty);
    return cnt < dty;
  endfunction

  // Last tick of a period.
  function automatic logic at_wrap(input logic [15:0] cnt, input logic [15:0] prd);
    return cnt == prd;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick_o,
  output logic          div_ok_o
);

  logic [DW-1:0] cnt_q;
  logic          last_w;

  assign div_ok_o = (div != '0);
  assign last_w   = (cnt_q == (div - DW'(1)));
  assign tick_o   = run && div_ok_o && last_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || !div_ok_o || last_w) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DW'(1);
    end
  end

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             div_ok,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] dty,
  output logic             active_o,
  output logic             boundary_o
);

  logic [CNT_W-1:0] cnt_q;

  assign boundary_o = tick && at_wrap(cnt_q, prd);
  assign active_o   = run && div_ok && duty_on(cnt_q, dty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (boundary_o) cnt_q <= '0;
      else            cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter bit HAS_BYPASS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  input  logic              pol,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              out_o,
  output logic              pend_o,
  output logic [DATA_W-1:0] shadow_o,
  output logic              tick_o,
  output logic              boundary_o,
  output logic              reserved_o
);

  localparam int PRD_MSB = DATA_W - 1;

  logic [DIV_W-1:0]  div_w;
  logic              div_ok_w;
  logic              active_w;
  logic              load_w;
  logic [DATA_W-1:0] shadow_q;
  logic              pend_q;
  logic [CNT_W-1:0]  prd_q;
  logic [CNT_W-1:0]  dty_q;

  assign div_w      = presc_div(code, HAS_BYPASS);
  assign reserved_o = !div_ok_w;
  assign load_w     = pend_q && (boundary_o || !run);

  pwm_prescaler #(.DW(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div      (div_w),
    .tick_o   (tick_o),
    .div_ok_o (div_ok_w)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick_o),
    .div_ok     (div_ok_w),
    .prd        (prd_q),
    .dty        (dty_q),
    .active_o   (active_w),
    .boundary_o (boundary_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
      prd_q    <= '0;
      dty_q    <= '0;
    end else begin
      if (wr) begin
        shadow_q <= wdata;
        pend_q   <= 1'b1;
      end else if (load_w) begin
        pend_q   <= 1'b0;
      end
      if (load_w) begin
        prd_q <= shadow_q[PRD_MSB -: CNT_W];
        dty_q <= shadow_q[CNT_W-1:0];
      end
    end
  end

  assign out_o    = active_w ? pol : !pol;
  assign pend_o   = pend_q;
  assign shadow_o = shadow_q;

endmodule

// File: rtl/twin_pwm_unit.sv
module twin_pwm_unit
  import pwm_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter bit HAS_BYPASS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam int FIELD_STRIDE = 15;
  localparam int B_EN         = 4;
  localparam int B_ACT        = 5;
  localparam int B_GATE       = 6;
  localparam int RDY_BASE     = 28;

  logic                          ctrl_wr;
  logic [NCH-1:0]                wr_ch;
  logic [NCH-1:0]                run_w;
  logic [NCH-1:0]                pol_w;
  logic [NCH-1:0]                gate_w;
  logic [NCH-1:0]                en_w;
  logic [NCH-1:0][CODE_W-1:0]    code_w;
  logic [NCH-1:0]                tick_w;
  logic [NCH-1:0]                bnd_w;
  logic [NCH-1:0]                pend_w;
  logic [NCH-1:0]                rsv_w;
  logic [NCH-1:0][DATA_W-1:0]    shadow_w;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(0));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int BASE = ch * FIELD_STRIDE;

    logic [CODE_W-1:0] code_r;
    logic              en_r;
    logic              act_r;
    logic              gate_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_r <= '0;
        en_r   <= 1'b0;
        act_r  <= 1'b0;
        gate_r <= 1'b0;
      end else if (ctrl_wr) begin
        en_r   <= bus_wdata[BASE + B_EN];
        act_r  <= bus_wdata[BASE + B_ACT];
        gate_r <= bus_wdata[BASE + B_GATE];
        if (!gate_r) code_r <= bus_wdata[BASE +: CODE_W];
      end
    end

    assign wr_ch[ch]  = bus_wr && (bus_addr == ADDR_W'(ch + 1));
    assign code_w[ch] = code_r;
    assign en_w[ch]   = en_r;
    assign pol_w[ch]  = act_r;
    assign gate_w[ch] = gate_r;
    assign run_w[ch]  = en_r && gate_r;

    pwm_channel #(
      .CNT_W      (CNT_W),
      .DATA_W     (DATA_W),
      .HAS_BYPASS (HAS_BYPASS)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run_w[ch]),
      .code       (code_r),
      .pol        (act_r),
      .wr         (wr_ch[ch]),
      .wdata      (bus_wdata),
      .out_o      (pwm_out[ch]),
      .pend_o     (pend_w[ch]),
      .shadow_o   (shadow_w[ch]),
      .tick_o     (tick_w[ch]),
      .boundary_o (bnd_w[ch]),
      .reserved_o (rsv_w[ch])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(0)) begin
      for (int ch = 0; ch < NCH; ch++) begin
        bus_rdata[ch*FIELD_STRIDE +: CODE_W]   = code_w[ch];
        bus_rdata[ch*FIELD_STRIDE + B_EN]      = en_w[ch];
        bus_rdata[ch*FIELD_STRIDE + B_ACT]     = pol_w[ch];
        bus_rdata[ch*FIELD_STRIDE + B_GATE]    = gate_w[ch];
        bus_rdata[RDY_BASE + ch]               = pend_w[ch];
      end
    end
    for (int ch = 0; ch < NCH; ch++) begin
      if (bus_addr == ADDR_W'(ch + 1)) bus_rdata = shadow_w[ch];
    end
  end

endmodule

// File: rtl/twin_pwm_chk.sv
module twin_pwm_chk #(
  parameter int NCH        = 2,
  parameter bit HAS_BYPASS = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH-1:0]      pwm_out,
  input logic [NCH-1:0]      run,
  input logic [NCH-1:0]      pol,
  input logic [NCH-1:0]      gate,
  input logic [NCH-1:0][3:0] code,
  input logic [NCH-1:0]      tick,
  input logic [NCH-1:0]      boundary,
  input logic [NCH-1:0]      pend,
  input logic [NCH-1:0]      wr_ch,
  input logic [NCH-1:0]      reserved
);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |-> (pwm_out[i] == !pol[i])); // R7

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && reserved[i]) |-> (pwm_out[i] == !pol[i])); // R4

    AST_CODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      gate[i] |=> $stable(code[i])); // R10

    AST_BYPASS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_BYPASS && run[i] && (code[i] == 4'hF)) |-> tick[i]); // R3

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ch[i] |=> pend[i]); // R9

    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && boundary[i] && !wr_ch[i]) |=> !pend[i]); // R9
  end

endmodule

bind twin_pwm_unit twin_pwm_chk #(.NCH(NCH), .HAS_BYPASS(HAS_BYPASS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_out  (pwm_out),
  .run      (run_w),
  .pol      (pol_w),
  .gate     (gate_w),
  .code     (code_w),
  .tick     (tick_w),
  .boundary (bnd_w),
  .pend     (pend_w),
  .wr_ch    (wr_ch),
  .reserved (rsv_w)
);

// File: tb/twin_pwm_unit_bench.sv
module twin_pwm_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_pwm_unit u_twin_pwm_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  typedef struct { int hi; int per; string tag; } exp_t;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  exp_t  q0[$];
  exp_t  q1[$];
  bit    seen [2];
  bit    prev [2];
  int    hi_c [2];
  int    tot_c [2];
  logic [31:0] ctrl_img = '0;
  logic [31:0] rv;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic score(input int c);
    exp_t e;
    bit   have;
    have = 1'b0;
    if (c == 0 && q0.size() > 0) begin e = q0.pop_front(); have = 1'b1; end
    if (c == 1 && q1.size() > 0) begin e = q1.pop_front(); have = 1'b1; end
    if (have) begin
      check(hi_c[c] == e.hi, {e.tag, " high"}, hi_c[c], e.hi);
      check(tot_c[c] == e.per, {e.tag, " period"}, tot_c[c], e.per);
    end
  endtask

  // Monitor: measures each full period between rising edges.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        logic s;
        s = pwm_out[c];
        if (s && !prev[c]) begin
          if (seen[c]) score(c);
          seen[c]  = 1'b1;
          tot_c[c] = 1;
          hi_c[c]  = 1;
        end else begin
          tot_c[c]++;
          if (s) hi_c[c]++;
        end
        prev[c] = s;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_ctrl(input int c, input logic [3:0] code, input bit en,
                          input bit act, input bit gate);
    logic [31:0] f;
    f = {25'b0, gate, act, en, code};
    ctrl_img = (ctrl_img & ~(32'h7F << (c*15))) | (f << (c*15));
    wr(2'd0, ctrl_img);
  endtask

  task automatic expect_periods(input int c, input int hi, input int per,
                                input int n, input string tag);
    exp_t e;
    int   guard;
    #1;
    seen[c] = 1'b0;
    e.hi = hi; e.per = per; e.tag = tag;
    for (int k = 0; k < n; k++) begin
      if (c == 0) q0.push_back(e); else q1.push_back(e);
    end
    guard = 0;
    while (((c == 0) ? q0.size() : q1.size()) != 0 && guard < 50000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 50000, {tag, " periods seen"}, guard, 0);
    q0.delete();
    q1.delete();
  endtask

  task automatic first_pulse(input int c, input logic [3:0] code, input int exp,
                             input string tag);
    int n;
    set_ctrl(c, code, 1'b0, 1'b1, 1'b0);
    wr(2'(c + 1), {16'd1, 16'd1});
    set_ctrl(c, code, 1'b1, 1'b1, 1'b1);
    n = 0;
    while (pwm_out[c] == 1'b1 && n < 100000) begin
      n++;
      @(negedge clk);
    end
    check(n == exp, tag, n, exp);
    set_ctrl(c, code, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic hold(input int c, input bit val, input int cycles, input string tag);
    int bad;
    bad = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (pwm_out[c] != val) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R8: reset state
    rd(2'd0, rv);
    check(rv == 32'h0, "R1 reset ctrl", rv, 0);
    rd(2'd1, rv);
    check(rv == 32'h0, "R1 reset ch0 word", rv, 0);
    check(pwm_out == 2'b11, "R8 reset idle level", pwm_out, 3);

    // R1: channel word readback, R9 stopped-channel load
    wr(2'd1, 32'hABCD_1234);
    rd(2'd0, rv);
    check(rv[28] == 1'b1, "R9 ready set after write", rv[28], 1);
    @(negedge clk);
    rd(2'd0, rv);
    check(rv[28] == 1'b0, "R9 ready clear when stopped", rv[28], 0);
    rd(2'd1, rv);
    check(rv == 32'hABCD_1234, "R1 ch0 readback", rv, 32'hABCD_1234);

    // R1: field layout, bits 7 and 8 not stored
    wr(2'd0, 32'h0000_01A0 | (32'h23 << 15));
    rd(2'd0, rv);
    check(rv == (32'h20 | (32'h23 << 15)), "R1 ctrl fields", rv, 32'h20 | (32'h23 << 15));
    ctrl_img = 32'h0;
    wr(2'd0, ctrl_img);

    // R2 / R3 / R11: first active interval equals the divider
    first_pulse(0, 4'd0, 120, "R2 R11 code0");
    first_pulse(0, 4'd1, 180, "R2 code1");
    first_pulse(0, 4'd2, 240, "R2 code2");
    first_pulse(0, 4'd3, 360, "R2 code3");
    first_pulse(0, 4'd4, 480, "R2 code4");
    first_pulse(0, 4'd8, 12000, "R2 code8");
    first_pulse(0, 4'd12, 72000, "R2 code12");
    first_pulse(1, 4'd15, 1, "R3 bypass first pulse");

    // R10: code change blocked while gated; R5 timing with code 0
    set_ctrl(0, 4'd0, 1'b0, 1'b1, 1'b0);
    wr(2'd1, {16'd3, 16'd1});
    set_ctrl(0, 4'd0, 1'b1, 1'b1, 1'b1);
    set_ctrl(0, 4'd1, 1'b1, 1'b1, 1'b1);
    rd(2'd0, rv);
    check(rv[3:0] == 4'd0, "R10 code locked", rv[3:0], 0);
    ctrl_img[3:0] = 4'd0;
    expect_periods(0, 120, 480, 2, "R5 R10 code0 P3 T1");
    set_ctrl(0, 4'd0, 1'b0, 1'b1, 1'b0);

    // R7: enable without gate, gate without enable
    set_ctrl(0, 4'd0, 1'b1, 1'b1, 1'b0);
    hold(0, 1'b0, 300, "R7 enable only");
    set_ctrl(0, 4'd0, 1'b0, 1'b1, 1'b1);
    hold(0, 1'b0, 300, "R7 gate only");
    set_ctrl(0, 4'd0, 1'b0, 1'b1, 1'b0);

    // R4: reserved code
    set_ctrl(0, 4'd5, 1'b0, 1'b1, 1'b0);
    set_ctrl(0, 4'd5, 1'b1, 1'b1, 1'b1);
    hold(0, 1'b0, 300, "R4 reserved code5");
    set_ctrl(0, 4'd5, 1'b0, 1'b1, 1'b0);

    // R5 / R3: bypass channel 1
    set_ctrl(1, 4'd15, 1'b0, 1'b1, 1'b0);
    wr(2'd2, {16'd9, 16'd3});
    set_ctrl(1, 4'd15, 1'b1, 1'b1, 1'b1);
    expect_periods(1, 3, 10, 3, "R5 R3 bypass P9 T3");

    // R9: update while running
    wr(2'd2, {16'd19, 16'd3});
    rd(2'd0, rv);
    check(rv[29] == 1'b1, "R9 ch1 pending", rv[29], 1);
    repeat (12) @(negedge clk);
    rd(2'd0, rv);
    check(rv[29] == 1'b0, "R9 ch1 loaded at boundary", rv[29], 0);
    expect_periods(1, 3, 20, 2, "R9 new period");

    // R8: inverted polarity
    set_ctrl(1, 4'd15, 1'b1, 1'b0, 1'b1);
    expect_periods(1, 17, 20, 2, "R8 inverted");

    // R6: duty at or above period, and zero duty
    set_ctrl(1, 4'd15, 1'b0, 1'b1, 1'b0);
    wr(2'd2, {16'd4, 16'd5});
    set_ctrl(1, 4'd15, 1'b1, 1'b1, 1'b1);
    hold(1, 1'b1, 30, "R6 full duty");
    wr(2'd2, {16'd4, 16'd0});
    repeat (8) @(negedge clk);
    hold(1, 1'b0, 30, "R6 zero duty");
    set_ctrl(1, 4'd15, 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule